// File: doc/BRIEF.md
# Flow-Gated Serial Byte Transmitter

This block turns bytes into asynchronous serial frames on a single output line. Each frame has one low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit lasts one interval of an external baud tick. Bytes enter through a valid/ready handshake into a holding stage. That stage is a single register when `BUF_DEPTH` is 1 and a small first-in first-out buffer when it is larger. Frames follow one another with no idle gap for as long as data is waiting.

When the flow-control enable is set, the transmitter looks at an active-low clear-to-send input. It does this only at the moment it could begin a new frame. A frame that has already started always runs to the end of its stop bit. A waiting byte stays in the holding stage until the peer lowers clear-to-send again.

The clear-to-send input passes through a multi-flop synchronizer. Each change of the synchronized level, in either direction, sets a sticky status flag while flow control is enabled. Software clears the flag by pulsing a write-one-to-clear input. An interrupt output follows the flag, masked by an enable bit.

Top module: `uart_cts_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `txd` is 1. After reset, `in_ready` is 1 and both `cts_flag` and `irq` are 0.
- R2: A frame is `txd`=0 for one bit, then the byte's bits 0 to 7 in that order, then `txd`=1 for one bit. `txd` changes only in the cycle after a cycle with `baud_tick`=1.
- R3: A byte is accepted in a cycle where `in_valid` and `in_ready` are both 1. Once `BUF_DEPTH` bytes are waiting, `in_ready` is 0.
- R4: With `cfg_flow_en`=1, a frame starts only if the synchronized `cts_n` is 0 at the baud tick that would start it. While `cts_n` is held at 1, no frame starts.
- R5: If `cts_n` rises while a frame is being sent, that frame completes including its stop bit, and the next waiting byte is not started.
- R6: A held byte is sent once `cts_n` returns to 0.
- R7: With `cfg_flow_en`=1, each rising or falling change of `cts_n` sets `cts_flag`. The flag becomes visible after the third rising clock edge that follows the change, and not before.
- R8: `cts_flag` stays at 1 until a cycle with `flag_clr`=1. If a new change is detected in the same cycle as the clear, the flag stays at 1.
- R9: `irq` is 1 exactly when `cts_flag` is 1 and `cfg_irq_en` is 1.
- R10: With `cfg_flow_en`=0, frames are sent whatever the level of `cts_n`, and `cts_flag` never sets.
- R11: When a byte is waiting at the end of a stop bit, the next start bit follows immediately. The start of consecutive frames is then exactly 10 bit periods apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| cfg_flow_en | input | 1 | Enables clear-to-send gating and flag setting |
| cfg_irq_en | input | 1 | Interrupt enable |
| in_data | input | DATA_W | Byte to transmit |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Holding stage can accept a byte |
| cts_n | input | 1 | Clear-to-send from peer, active low, asynchronous |
| flag_clr | input | 1 | Write-one-to-clear for `cts_flag` |
| cts_flag | output | 1 | Sticky clear-to-send change flag |
| irq | output | 1 | Interrupt request |
| txd | output | 1 | Serial output line, idle high |

## Verification
The bench builds the block with `BUF_DEPTH`=2, `SYNC_STAGES`=2 and eight data bits. With these values the buffered variant of the holding stage is exercised. Two bytes can therefore wait at once, which makes it possible to observe back-to-back frames, a full buffer with `in_ready` low, and a second byte held behind a frame that was stopped mid-flight. The two-stage synchronizer fixes the flag latency at three clock edges. This allows the bench to line up a clear pulse exactly with a detected change.

// File: rtl/uart_cts_pkg.sv
package uart_cts_pkg;

   // Synchronized clear-to-send levels (input is active low)
   typedef enum logic {
      LINE_CLEAR = 1'b0,
      LINE_HOLD  = 1'b1
   } cts_lvl_e;

   // Bits per frame: start + data + stop
   function automatic int unsigned frame_bits(input int unsigned data_w);
      return data_w + 2;
   endfunction

endpackage

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n,
   output logic level,
   output logic toggled
);
   if (STAGES < 2) begin : g_bad_stages
      $error("uart_cts_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], async_n};
         prev  <= chain[STAGES-1];
      end
   end

   assign level   = chain[STAGES-1];
   assign toggled = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic              rd_avail,
   output logic [DATA_W-1:0] rd_data,
   input  logic              rd_take
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("uart_tx_hold: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_reg
      logic              full;
      logic [DATA_W-1:0] store;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full  <= 1'b0;
            store <= '0;
         end else if (rd_take) begin
            full <= 1'b0;
         end else if (wr_valid && !full) begin
            full  <= 1'b1;
            store <= wr_data;
         end
      end

      assign wr_ready = !full;
      assign rd_avail = full;
      assign rd_data  = store;
   end else begin : g_fifo
      localparam int unsigned AW = $clog2(DEPTH);
      localparam int unsigned CW = $clog2(DEPTH + 1);

      logic [DATA_W-1:0] mem [DEPTH];
      logic [AW-1:0]     wp, rp;
      logic [CW-1:0]     cnt;
      logic              push, pop;

      assign push = wr_valid && wr_ready;
      assign pop  = rd_take && rd_avail;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
         end else begin
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (push) mem[wp] <= wr_data;
      end

      assign wr_ready = (cnt != CW'(DEPTH));
      assign rd_avail = (cnt != '0);
      assign rd_data  = mem[rp];
   end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
   import uart_cts_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              permit,
   input  logic              avail,
   input  logic [DATA_W-1:0] data,
   output logic              take,
   output logic              active,
   output logic              txd
);
   localparam int unsigned FL = frame_bits(DATA_W);
   localparam int unsigned CW = $clog2(FL + 1);

   logic [FL-1:0] sh;
   logic [CW-1:0] left;
   logic          at_boundary;

   assign at_boundary = (left <= CW'(1));
   assign take        = baud_tick && at_boundary && avail && permit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         left <= '0;
      end else if (baud_tick) begin
         if (at_boundary) begin
            if (avail && permit) begin
               sh   <= {1'b1, data, 1'b0};
               left <= CW'(FL);
            end else begin
               sh   <= '1;
               left <= '0;
            end
         end else begin
            sh   <= {1'b1, sh[FL-1:1]};
            left <= left - 1'b1;
         end
      end
   end

   assign active = (left != '0);
   assign txd    = active ? sh[0] : 1'b1;
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
   import uart_cts_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned BUF_DEPTH   = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              cfg_flow_en,
   input  logic              cfg_irq_en,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              cts_n,
   input  logic              flag_clr,
   output logic              cts_flag,
   output logic              irq,
   output logic              txd
);
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("uart_cts_tx: DATA_W must be between 5 and 9");
   end

   logic              cts_lvl;
   logic              cts_chg;
   logic              hold_avail;
   logic              hold_take;
   logic [DATA_W-1:0] hold_data;
   logic              tx_permit;
   logic              tx_active;
   logic              flag_q;

   uart_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_n (cts_n),
      .level   (cts_lvl),
      .toggled (cts_chg)
   );

   uart_tx_hold #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (in_valid),
      .wr_data  (in_data),
      .wr_ready (in_ready),
      .rd_avail (hold_avail),
      .rd_data  (hold_data),
      .rd_take  (hold_take)
   );

   assign tx_permit = !cfg_flow_en || (cts_lvl == LINE_CLEAR);

   uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .permit    (tx_permit),
      .avail     (hold_avail),
      .data      (hold_data),
      .take      (hold_take),
      .active    (tx_active),
      .txd       (txd)
   );

   // Sticky change flag: a detected change wins over a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     flag_q <= 1'b0;
      else if (cfg_flow_en && cts_chg) flag_q <= 1'b1;
      else if (flag_clr)              flag_q <= 1'b0;
   end

   assign cts_flag = flag_q;
   assign irq      = flag_q && cfg_irq_en;
endmodule

// File: rtl/uart_cts_tx_chk.sv
module uart_cts_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic cfg_flow_en,
   input logic cfg_irq_en,
   input logic flag_clr,
   input logic cts_flag,
   input logic irq,
   input logic txd,
   input logic line_active,
   input logic frame_take,
   input logic cts_level
);
   assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !line_active |-> txd);

   assert_bit_pace_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(txd) |-> $past(baud_tick));

   assert_start_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_take && cfg_flow_en) |-> !cts_level);

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cts_flag && !flag_clr) |=> cts_flag);

   assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_irq_en |-> !irq);

   assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cts_flag && cfg_irq_en) |-> irq);

   assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cts_flag) |-> $past(cfg_flow_en));
endmodule

bind uart_cts_tx uart_cts_tx_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .baud_tick   (baud_tick),
   .cfg_flow_en (cfg_flow_en),
   .cfg_irq_en  (cfg_irq_en),
   .flag_clr    (flag_clr),
   .cts_flag    (cts_flag),
   .irq         (irq),
   .txd         (txd),
   .line_active (tx_active),
   .frame_take  (hold_take),
   .cts_level   (cts_lvl)
);

// File: tb/sim_uart_cts_tx.sv
`timescale 1ns/1ps
module sim_uart_cts_tx;
   localparam int DW  = 8;
   localparam int DIV = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_tick = 1'b0;
   logic cfg_flow_en = 1'b0;
   logic cfg_irq_en = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic cts_n = 1'b1;
   logic flag_clr = 1'b0;
   logic cts_flag;
   logic irq;
   logic txd;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [DW-1:0] expq[$];

   always #2 clk = ~clk;

   uart_cts_tx #(.DATA_W(DW), .BUF_DEPTH(2), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .cfg_flow_en(cfg_flow_en), .cfg_irq_en(cfg_irq_en),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .cts_n(cts_n), .flag_clr(flag_clr), .cts_flag(cts_flag),
      .irq(irq), .txd(txd)
   );

   // baud tick: one cycle in every DIV, driven away from the active edge
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         cnt = (cnt == DIV - 1) ? 0 : cnt + 1;
         baud_tick = (cnt == DIV - 1);
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor / scoreboard
   logic tick_p = 1'b0;
   int smp_idx = 0;
   int rx_cnt = 0;
   int bitpos = -1;
   int last_start = 0;
   int prev_start = 0;
   logic [DW-1:0] acc;

   always @(posedge clk) tick_p <= baud_tick && rst_n;

   always @(negedge clk) begin
      if (tick_p) begin
         smp_idx++;
         if (bitpos < 0) begin
            if (!txd) begin
               bitpos = 0;
               prev_start = last_start;
               last_start = smp_idx;
            end
         end else if (bitpos < DW) begin
            acc[bitpos] = txd;
            bitpos++;
         end else begin
            chk(txd == 1'b1, "R2", "stop bit", txd, 1);
            if (expq.size() == 0) begin
               chk(0, "R2", "unexpected frame", acc, 0);
            end else begin
               logic [DW-1:0] e;
               e = expq.pop_front();
               chk(acc == e, "R2", "frame data", acc, e);
            end
            rx_cnt++;
            bitpos = -1;
         end
      end
   end

   // driver: pushes the expected byte when the handshake completes
   task automatic send(input logic [DW-1:0] b);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      @(posedge clk);
      expq.push_back(b);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_rx(input int target, input string req);
      int n = 0;
      while (rx_cnt < target && n < 2000) begin
         @(posedge clk);
         n++;
      end
      chk(rx_cnt >= target, req, "frames received", rx_cnt, target);
   endtask

   task automatic clear_flag();
      @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=completion");
      report();
   end

   initial begin
      int base;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      chk(txd == 1'b1, "R1", "idle txd", txd, 1);
      chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
      chk(cts_flag == 1'b0, "R1", "flag after reset", cts_flag, 0);
      chk(irq == 1'b0, "R1", "irq after reset", irq, 0);

      // R10 / R11: flow disabled, cts_n held high, two bytes back to back
      send(8'hA5);
      send(8'h3C);
      wait_rx(2, "R10");
      chk(last_start - prev_start == 10, "R11", "start spacing",
          last_start - prev_start, 10);
      repeat (3) begin
         @(negedge clk) cts_n = ~cts_n;
         repeat (4) @(negedge clk);
      end
      chk(cts_flag == 1'b0, "R10", "flag with flow off", cts_flag, 0);
      chk(txd == 1'b1, "R1", "idle txd after frames", txd, 1);

      // R7: falling change, latency of three edges
      @(negedge clk) cts_n = 1'b1;
      repeat (6) @(negedge clk);
      cfg_flow_en = 1'b1;
      @(negedge clk) cts_n = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      chk(cts_flag == 1'b0, "R7", "flag before third edge", cts_flag, 0);
      @(negedge clk);
      chk(cts_flag == 1'b1, "R7", "flag on falling change", cts_flag, 1);
      chk(irq == 1'b0, "R9", "irq masked", irq, 0);
      cfg_irq_en = 1'b1;
      @(negedge clk);
      chk(irq == 1'b1, "R9", "irq enabled", irq, 1);
      repeat (5) @(negedge clk);
      chk(cts_flag == 1'b1, "R8", "flag sticky", cts_flag, 1);
      clear_flag();
      chk(cts_flag == 1'b0, "R8", "flag cleared", cts_flag, 0);
      chk(irq == 1'b0, "R9", "irq follows clear", irq, 0);

      // R7: rising change
      @(negedge clk) cts_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(cts_flag == 1'b1, "R7", "flag on rising change", cts_flag, 1);
      clear_flag();

      // R8: change detected in the same cycle as the clear
      @(negedge clk) cts_n = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk) flag_clr = 1'b1;
      @(negedge clk) flag_clr = 1'b0;
      chk(cts_flag == 1'b1, "R8", "change beats clear", cts_flag, 1);
      @(negedge clk) cts_n = 1'b1;
      repeat (6) @(negedge clk);
      clear_flag();

      // R4 / R3: blocked, fill the buffer
      base = rx_cnt;
      send(8'h5A);
      send(8'hC3);
      @(negedge clk);
      chk(in_ready == 1'b0, "R3", "ready low when full", in_ready, 0);
      repeat (200) @(negedge clk);
      chk(rx_cnt == base, "R4", "no frame while blocked", rx_cnt, base);
      chk(txd == 1'b1, "R4", "line idle while blocked", txd, 1);

      // R6: release
      @(negedge clk) cts_n = 1'b0;
      wait_rx(base + 2, "R6");
      clear_flag();

      // R5: raise cts_n mid-frame
      base = rx_cnt;
      send(8'h81);
      send(8'h7E);
      begin
         int n = 0;
         while (bitpos != 4 && n < 2000) begin
            @(posedge clk);
            n++;
         end
      end
      @(negedge clk) cts_n = 1'b1;
      wait_rx(base + 1, "R5");
      repeat (120) @(negedge clk);
      chk(rx_cnt == base + 1, "R5", "next frame held", rx_cnt, base + 1);
      chk(bitpos == -1, "R5", "no frame in progress", bitpos, -1);
      @(negedge clk) cts_n = 1'b0;
      wait_rx(base + 2, "R6");
      chk(expq.size() == 0, "R2", "scoreboard drained", expq.size(), 0);

      repeat (10) @(negedge clk);
      report();
   end
endmodule